// File: doc/BRIEF.md
# Frequency Synthesizer Lock Controller

This block is the digital control wrapped around a frequency synthesizer. It keeps the reference divide ratio, the multiplier setting, a lock-wait count and a halving option in one configuration register. From these it derives the synthesizer enable and the ratio it will produce. The analog loop is not modelled: the synthesizer appears only through its enable and its parameters. Lock is a timer, not a phase measurement. When the loop is switched on again or any of its parameters changes, the lock flag drops. A countdown, loaded with the programmed settling count, then runs on strobes from a slow clock. The flag returns when the countdown expires.

A digital reference divider thins a stream of source-clock strobes by the programmed ratio. A final stage passes strobes of a modelled synthesizer clock, optionally halved. Software writes the whole configuration in one cycle through a plain write strobe. The lock flag, the interrupt and the ratio terms are plain level outputs. No port carries streaming data, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, the divide ratio is 0, the multiplier is 0, lock and interrupt are low, the synthesizer enable is low, and neither strobe output pulses.
- R2: While the divide ratio is 0, `ref_tick` and `syn_out` stay at 0 whatever the input strobes do.
- R3: With a divide ratio D from 1 to 255, `ref_tick` equals `src_tick` on every D-th source strobe. The phase count restarts at zero on every configuration change (see R6). The pulse appears in the same cycle as the strobe that completes the count.
- R4: `ratio_num` reports multiplier+1 and `ratio_den` reports the divide ratio. Both reflect a write from the cycle after it.
- R5: `syn_en` is high exactly when the stored multiplier is nonzero, from the cycle after the write.
- R6: A write that changes the divide ratio, the multiplier or the lock count (this includes going from multiplier 0 to nonzero) clears `locked` in the next cycle and loads the countdown with the new count. A slow tick in that same cycle is not counted.
- R7: After such a load with count N, `locked` rises in the cycle after the max(N,1)-th slow tick. A count of 0 therefore locks on the first tick.
- R8: While the multiplier or the divide ratio is 0, the countdown does not run and `locked` stays 0.
- R9: A write that leaves the divide ratio, the multiplier and the lock count unchanged neither clears `locked` nor restarts the countdown. This holds even when it changes the halving bit.
- R10: `lock_irq` equals `locked` AND `irq_en`, with no delay.
- R11: `syn_out` passes `syn_tick` only while `syn_en` is high and the divide ratio is nonzero. With the halving bit set it passes every second such strobe, starting with the second one after a configuration change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_div | input | 8 | Reference divide ratio; 0 silences the outputs |
| cfg_mul | input | 8 | Multiplier field; 0 powers the synthesizer down |
| cfg_cnt | input | 6 | Lock-wait count in slow ticks |
| cfg_half | input | 1 | Halve the synthesizer output strobes |
| irq_en | input | 1 | Lock interrupt enable |
| slow_tick | input | 1 | Slow-clock enable strobe |
| src_tick | input | 1 | Source-clock strobe into the reference divider |
| syn_tick | input | 1 | Modelled synthesizer clock strobe |
| syn_en | output | 1 | Synthesizer enable |
| locked | output | 1 | Sticky lock status |
| lock_irq | output | 1 | Lock interrupt |
| ratio_num | output | 9 | Multiplication term, multiplier+1 |
| ratio_den | output | 8 | Division term, the divide ratio |
| ref_tick | output | 1 | Divided reference strobe |
| syn_out | output | 1 | Gated, optionally halved synthesizer strobe |

## Verification
The strobe outputs `ref_tick` and `syn_out` and the interrupt are combinational, so they are due in the same cycle as the input strobe or enable that causes them. Register results appear one clock after the write or the tick that causes them: the ratio terms, the enable, the lock clear and the lock set. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge and compares every output two nanoseconds after the next falling edge, so each result is sampled in the cycle where it is due. Directed checks read the lock flag one sample after a changing write and after a repeated write, and keep reading it through long idle stretches with a zero field.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int DIV_W = 8;
  localparam int MUL_W = 8;
  localparam int CNT_W = 6;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [MUL_W-1:0] mul;
    logic [CNT_W-1:0] cnt;
    logic             half;
  } syn_cfg_t;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  syn_cfg_t wr_cfg,
  output syn_cfg_t cfg_q,
  output logic     load,
  output logic     load_run
);
  logic differs;

  // Only the loop parameters count as a change; the halving bit does not.
  assign differs  = (wr_cfg.div != cfg_q.div) || (wr_cfg.mul != cfg_q.mul) ||
                    (wr_cfg.cnt != cfg_q.cnt);
  assign load     = we && differs;
  assign load_run = (wr_cfg.mul != '0) && (wr_cfg.div != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wr_cfg;
  end

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == $past(wr_cfg)));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_run,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             active,
  input  logic             tick,
  output logic             lock
);
  logic [CNT_W-1:0] remain;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
      lock   <= 1'b0;
    end else if (load) begin
      remain <= load_cnt;
      armed  <= load_run;
      lock   <= 1'b0;
    end else if (!active) begin
      armed  <= 1'b0;
      lock   <= 1'b0;
    end else if (armed && tick) begin
      if (remain <= CNT_W'(1)) begin
        lock  <= 1'b1;
        armed <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  assert_lock_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !lock);
  assert_idle_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !lock);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !load && active) |=> lock);
  assert_lock_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(tick));
endmodule

// File: rtl/pll_ref_divider.sv
module pll_ref_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  input  logic         src_tick,
  output logic         ref_tick
);
  logic [W-1:0] phase;
  logic         wrap;

  assign wrap     = (ratio != '0) && (phase == ratio - 1'b1);
  assign ref_tick = src_tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          phase <= '0;
    else if (restart)                    phase <= '0;
    else if (src_tick && ratio != '0)    phase <= wrap ? '0 : phase + 1'b1;
  end

  assert_zero_ratio_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == '0) |-> !ref_tick);
endmodule

// File: rtl/pll_out_gate.sv
module pll_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic half,
  input  logic enable,
  input  logic in_tick,
  output logic out_tick
);
  logic pass;
  logic odd;

  assign pass     = in_tick && enable;
  assign out_tick = pass && (!half || odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       odd <= 1'b0;
    else if (restart) odd <= 1'b0;
    else if (!half)   odd <= 1'b0;
    else if (pass)    odd <= ~odd;
  end

  assert_gate_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !out_tick);
  assert_half_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tick && half && !restart) |=> !(out_tick && half));
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [MUL_W-1:0] cfg_mul,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             cfg_half,
  input  logic             irq_en,
  input  logic             slow_tick,
  input  logic             src_tick,
  input  logic             syn_tick,
  output logic             syn_en,
  output logic             locked,
  output logic             lock_irq,
  output logic [MUL_W:0]   ratio_num,
  output logic [DIV_W-1:0] ratio_den,
  output logic             ref_tick,
  output logic             syn_out
);
  syn_cfg_t wr_cfg;
  syn_cfg_t cfg_q;
  logic     load;
  logic     load_run;
  logic     div_live;
  logic     running;

  assign wr_cfg = '{div: cfg_div, mul: cfg_mul, cnt: cfg_cnt, half: cfg_half};

  pll_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_cfg(wr_cfg),
    .cfg_q(cfg_q), .load(load), .load_run(load_run)
  );

  assign syn_en    = (cfg_q.mul != '0);
  assign div_live  = (cfg_q.div != '0);
  assign running   = syn_en && div_live;
  assign ratio_num = {1'b0, cfg_q.mul} + (MUL_W+1)'(1);
  assign ratio_den = cfg_q.div;

  pll_lock_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_run(load_run),
    .load_cnt(cfg_cnt), .active(running), .tick(slow_tick), .lock(locked)
  );

  assign lock_irq = locked && irq_en;

  pll_ref_divider #(.W(DIV_W)) u_refdiv (
    .clk(clk), .rst_n(rst_n), .restart(load), .ratio(cfg_q.div),
    .src_tick(src_tick), .ref_tick(ref_tick)
  );

  pll_out_gate u_gate (
    .clk(clk), .rst_n(rst_n), .restart(load), .half(cfg_q.half),
    .enable(running), .in_tick(syn_tick), .out_tick(syn_out)
  );

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_irq |-> (locked && irq_en));
  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_en |-> (!locked && !syn_out));
endmodule

// File: tb/sim_pll_lock_ctrl.sv
module sim_pll_lock_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [7:0] cfg_mul = '0;
  logic [5:0] cfg_cnt = '0;
  logic cfg_half = 1'b0;
  logic irq_en = 1'b0;
  logic slow_tick = 1'b0;
  logic src_tick = 1'b0;
  logic syn_tick = 1'b0;
  logic syn_en, locked, lock_irq, ref_tick, syn_out;
  logic [8:0] ratio_num;
  logic [7:0] ratio_den;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_div = 0, m_mul = 0, m_cnt = 0, m_half = 0;
  int m_timer = 0, m_armed = 0, m_lock = 0, m_rc = 0, m_ph = 0;

  always #4 clk = ~clk;

  pll_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_mul(cfg_mul), .cfg_cnt(cfg_cnt), .cfg_half(cfg_half),
    .irq_en(irq_en), .slow_tick(slow_tick), .src_tick(src_tick),
    .syn_tick(syn_tick), .syn_en(syn_en), .locked(locked),
    .lock_irq(lock_irq), .ratio_num(ratio_num), .ratio_den(ratio_den),
    .ref_tick(ref_tick), .syn_out(syn_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_mul = 0; m_cnt = 0; m_half = 0;
      m_timer = 0; m_armed = 0; m_lock = 0; m_rc = 0; m_ph = 0;
    end else begin
      bit chg, act, g;
      chg = cfg_we && (cfg_div != m_div || cfg_mul != m_mul || cfg_cnt != m_cnt);
      act = (m_mul != 0) && (m_div != 0);
      g   = syn_tick && act;
      if (chg) m_rc = 0;
      else if (src_tick && m_div != 0) m_rc = (m_rc == m_div - 1) ? 0 : m_rc + 1;
      if (chg || !m_half) m_ph = 0;
      else if (g) m_ph = 1 - m_ph;
      if (chg) begin
        m_lock = 0; m_timer = cfg_cnt; m_armed = (cfg_mul != 0 && cfg_div != 0);
      end else if (!act) begin
        m_lock = 0; m_armed = 0;
      end else if (m_armed && slow_tick) begin
        if (m_timer <= 1) begin m_lock = 1; m_armed = 0; end
        else m_timer--;
      end
      if (cfg_we) begin
        m_div = cfg_div; m_mul = cfg_mul; m_cnt = cfg_cnt; m_half = cfg_half;
      end
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit act;
      act = (m_mul != 0) && (m_div != 0);
      chk("R4 num", ratio_num, m_mul + 1);
      chk("R4 den", ratio_den, m_div);
      chk("R5 syn_en", syn_en, m_mul != 0);
      chk("R7 locked", locked, m_lock);
      chk("R10 irq", lock_irq, m_lock && irq_en);
      chk("R3 ref_tick", ref_tick, src_tick && m_div != 0 && m_rc == m_div - 1);
      chk("R11 syn_out", syn_out, syn_tick && act && (!m_half || m_ph == 1));
    end
  end

  // background strobes
  initial begin
    forever begin
      @(negedge clk);
      src_tick = ($urandom_range(0, 3) != 0);
      syn_tick = ($urandom_range(0, 2) != 0);
    end
  end
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  task automatic wr(input int d, input int m, input int c, input int h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 8'(d); cfg_mul = 8'(m); cfg_cnt = 6'(c); cfg_half = h[0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 den", ratio_den, 0);
    chk("R1 syn_en", syn_en, 0);
    chk("R1 locked", locked, 0);
    chk("R1 ref_tick", ref_tick, 0);
    chk("R1 syn_out", syn_out, 0);
    idle(10);
    chk("R2 ref quiet at div 0", ref_tick, 0);
    chk("R8 no lock at reset config", locked, 0);

    irq_en = 1'b1;
    wr(3, 5, 4, 0);
    #2 chk("R6 cleared after enable", locked, 0);
    idle(40);
    chk("R7 locked after count", locked, 1);
    chk("R10 irq raised", lock_irq, 1);

    // identical loop fields, halving toggled: must keep lock (R9)
    wr(3, 5, 4, 1);
    #2 chk("R9 same write keeps lock", locked, 1);
    idle(30);

    // change count only
    wr(3, 5, 0, 1);
    #2 chk("R6 count change clears", locked, 0);
    idle(12);
    chk("R7 zero count locks on tick", locked, 1);

    irq_en = 1'b0;
    wr(1, 5, 1, 0);
    idle(20);
    irq_en = 1'b1;

    // multiplier off
    wr(1, 0, 2, 0);
    idle(40);
    chk("R8 no lock with mul 0", locked, 0);
    chk("R5 disabled", syn_en, 0);

    // re-enable, then divider zero
    wr(255, 7, 3, 1);
    idle(300);
    wr(0, 7, 3, 0);
    idle(30);
    #2;
    chk("R2 ref quiet at div 0", ref_tick, 0);
    chk("R2 syn quiet at div 0", syn_out, 0);
    chk("R8 no lock with div 0", locked, 0);

    wr(2, 200, 63, 1);
    idle(300);
    chk("R7 long count locked", locked, 1);
    wr(4, 9, 6, 0);
    idle(50);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule